// File: doc/BRIEF.md
# Offset Programmable Counter Divider Pair

This block holds the two integer dividers of a frequency synthesizer. The reference channel divides its clock by a 7-bit word plus 2. The feedback channel divides its clock by a 9-bit word plus 8. Each channel has its own clock, and each produces two outputs: a single-cycle pulse once per division period, and a toggle output that changes level on every pulse. The phase comparator, charge pump and oscillator that would use these outputs lie outside the block.

Each channel checks its word against a lowest legal code. A word below that code raises an invalid flag, and the channel divides as if the lowest legal word had been given. A word that is left unconfigured should be tied to all ones, which selects the largest ratio. The word may change at any time. A channel picks up a new word only when a period ends, so a period always finishes with the ratio it started with. The shared active-low power-down input stops both counters and holds both pairs of outputs low. When power-down is released, counting restarts from zero.

Top module: `synth_div_pair`

## Requirements
- R1: The reference channel produces exactly one pulse every W+2 of its clock cycles, where W is the 7-bit reference word and W is between 1 and 127.
- R2: The feedback channel produces exactly one pulse every W+8 of its clock cycles, where W is the 9-bit feedback word and W is between 4 and 511.
- R3: Each pulse is high for exactly one clock cycle. After reset is released, the first pulse is registered on the rising edge that comes N edges after the first edge that sees reset released and power-down high, where N is the ratio. This means a full period elapses before the first pulse.
- R4: The toggle output is low after reset and after power-down. It changes level on the same edge as each pulse and on no other edge, so its period is twice the ratio.
- R5: A reference word of 0, or a feedback word from 0 to 3, sets that channel's invalid flag on the next clock edge. The channel then divides by the lowest legal ratio: 3 for the reference channel and 12 for the feedback channel. A legal word clears the flag on the next edge.
- R6: An all-ones word gives the largest ratio: 129 for the reference channel and 519 for the feedback channel.
- R7: A word that changes partway through a period has no effect on that period. The new ratio applies from the period that starts at the next pulse.
- R8: While power-down is low, both pulse outputs and both toggle outputs are low from the first clock edge onward, and no pulse occurs.
- R9: After power-down is released, a channel's first pulse comes a full ratio of edges after its first edge with power-down high, following the same timing as after reset.
- R10: While reset is asserted, all pulse, toggle and invalid outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Clock of the reference channel |
| fb_clk | input | 1 | Clock of the feedback channel |
| rst_n | input | 1 | Asynchronous active-low reset for both channels |
| pd_n | input | 1 | Active-low power-down for both channels |
| ref_word | input | 7 | Reference divide word; ratio is word + 2 |
| fb_word | input | 9 | Feedback divide word; ratio is word + 8 |
| ref_pulse | output | 1 | One-cycle pulse per reference period |
| ref_toggle | output | 1 | Reference output that changes level at each pulse |
| ref_bad | output | 1 | Reference word is below the legal range |
| fb_pulse | output | 1 | One-cycle pulse per feedback period |
| fb_toggle | output | 1 | Feedback output that changes level at each pulse |
| fb_bad | output | 1 | Feedback word is below the legal range |

## Verification
The hardest case to create from the ports is a word change that lands in the middle of a period. The stimulus first waits for a pulse, counts a few cycles into the next period, and only then writes the new word. The measured gap must equal the old ratio, and the gap after it must equal the new ratio. The reference word is swept over every code and the feedback word over its illegal codes, its low codes and its top codes, with each expected period worked out arithmetically. A long power-down window with a word change inside it shows that nothing escapes while the block is stopped, and that the first period after release has full length.

// File: rtl/synth_div_pkg.sv
package synth_div_pkg;

    localparam int REF_WORD_W   = 7;
    localparam int REF_OFFSET   = 2;
    localparam int REF_MIN_WORD = 1;

    localparam int FB_WORD_W    = 9;
    localparam int FB_OFFSET    = 8;
    localparam int FB_MIN_WORD  = 4;

    typedef enum logic [0:0] {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } div_phase_e;

endpackage

// File: rtl/word_guard.sv
module word_guard #(
    parameter int WORD_W   = 7,
    parameter int OFFSET   = 2,
    parameter int MIN_WORD = 1,
    parameter int RATIO_W  = 8
) (
    input  logic [WORD_W-1:0]  word_i,
    output logic [RATIO_W-1:0] term_o,
    output logic               illegal_o
);

    localparam logic [WORD_W-1:0]  MIN_CODE = WORD_W'(MIN_WORD);
    localparam logic [RATIO_W-1:0] TERM_ADD = RATIO_W'(OFFSET - 1);

    logic [WORD_W-1:0] eff_word;

    generate
        if (MIN_WORD == 0) begin : g_no_floor
            assign illegal_o = 1'b0;
        end else begin : g_floor
            assign illegal_o = (word_i < MIN_CODE);
        end
    endgenerate

    always_comb begin
        eff_word = illegal_o ? MIN_CODE : word_i;
        term_o   = RATIO_W'(eff_word) + TERM_ADD;
    end

endmodule

// File: rtl/div_core.sv
module div_core
    import synth_div_pkg::*;
#(
    parameter int RATIO_W  = 8,
    parameter int TERM_MIN = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pd_n,
    input  logic [RATIO_W-1:0] term_i,
    input  logic               bad_i,
    output logic               pulse_o,
    output logic               toggle_o,
    output logic               bad_o
);

    localparam logic [RATIO_W-1:0] TERM_FLOOR = RATIO_W'(TERM_MIN);

    typedef struct packed {
        div_phase_e         phase;
        logic [RATIO_W-1:0] cnt;
        logic [RATIO_W-1:0] term;
        logic               pulse;
        logic               tog;
        logic               bad;
    } core_state_t;

    core_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        st_d.bad   = bad_i;
        if (!pd_n) begin
            st_d.phase = PH_IDLE;
            st_d.cnt   = '0;
            st_d.tog   = 1'b0;
        end else if (st_q.phase == PH_IDLE) begin
            st_d.phase = PH_RUN;
            st_d.cnt   = '0;
            st_d.term  = term_i;
        end else if (st_q.cnt == st_q.term) begin
            st_d.cnt   = '0;
            st_d.term  = term_i;
            st_d.pulse = 1'b1;
            st_d.tog   = ~st_q.tog;
        end else begin
            st_d.cnt   = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_IDLE;
            st_q.cnt   <= '0;
            st_q.term  <= TERM_FLOOR;
            st_q.pulse <= 1'b0;
            st_q.tog   <= 1'b0;
            st_q.bad   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse_o  = st_q.pulse;
    assign toggle_o = st_q.tog;
    assign bad_o    = st_q.bad;

    assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_RUN) |-> (st_q.cnt <= st_q.term));

    assert_pulse_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);

    assert_toggle_with_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_n && st_q.phase == PH_RUN) |=> ((toggle_o != $past(toggle_o)) == pulse_o));

    assert_term_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_RUN) |-> (st_q.term >= TERM_FLOOR));

    assert_ratio_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_n && st_q.phase == PH_RUN && st_q.cnt != st_q.term) |=> $stable(st_q.term));

    assert_pd_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_n |=> (!pulse_o && !toggle_o));

    assert_pd_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pd_n) |=> (st_q.phase == PH_RUN && st_q.cnt == '0));

endmodule

// File: rtl/offset_div.sv
module offset_div #(
    parameter int WORD_W   = 7,
    parameter int OFFSET   = 2,
    parameter int MIN_WORD = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pd_n,
    input  logic [WORD_W-1:0] word_i,
    output logic              pulse_o,
    output logic              toggle_o,
    output logic              bad_o
);

    localparam int RATIO_W  = $clog2((2 ** WORD_W) + OFFSET);
    localparam int TERM_MIN = MIN_WORD + OFFSET - 1;

    logic [RATIO_W-1:0] term;
    logic               illegal;

    word_guard #(
        .WORD_W  (WORD_W),
        .OFFSET  (OFFSET),
        .MIN_WORD(MIN_WORD),
        .RATIO_W (RATIO_W)
    ) u_guard (
        .word_i   (word_i),
        .term_o   (term),
        .illegal_o(illegal)
    );

    div_core #(
        .RATIO_W (RATIO_W),
        .TERM_MIN(TERM_MIN)
    ) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .pd_n    (pd_n),
        .term_i  (term),
        .bad_i   (illegal),
        .pulse_o (pulse_o),
        .toggle_o(toggle_o),
        .bad_o   (bad_o)
    );

endmodule

// File: rtl/synth_div_pair.sv
module synth_div_pair
    import synth_div_pkg::*;
(
    input  logic                  ref_clk,
    input  logic                  fb_clk,
    input  logic                  rst_n,
    input  logic                  pd_n,
    input  logic [REF_WORD_W-1:0] ref_word,
    input  logic [FB_WORD_W-1:0]  fb_word,
    output logic                  ref_pulse,
    output logic                  ref_toggle,
    output logic                  ref_bad,
    output logic                  fb_pulse,
    output logic                  fb_toggle,
    output logic                  fb_bad
);

    offset_div #(
        .WORD_W  (REF_WORD_W),
        .OFFSET  (REF_OFFSET),
        .MIN_WORD(REF_MIN_WORD)
    ) u_ref_div (
        .clk     (ref_clk),
        .rst_n   (rst_n),
        .pd_n    (pd_n),
        .word_i  (ref_word),
        .pulse_o (ref_pulse),
        .toggle_o(ref_toggle),
        .bad_o   (ref_bad)
    );

    offset_div #(
        .WORD_W  (FB_WORD_W),
        .OFFSET  (FB_OFFSET),
        .MIN_WORD(FB_MIN_WORD)
    ) u_fb_div (
        .clk     (fb_clk),
        .rst_n   (rst_n),
        .pd_n    (pd_n),
        .word_i  (fb_word),
        .pulse_o (fb_pulse),
        .toggle_o(fb_toggle),
        .bad_o   (fb_bad)
    );

endmodule

// File: tb/synth_div_pair_tb.sv
module synth_div_pair_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       pd_n;
    logic [6:0] ref_word;
    logic [8:0] fb_word;
    logic       ref_pulse, ref_toggle, ref_bad;
    logic       fb_pulse, fb_toggle, fb_bad;

    int n_checks = 0;
    int n_fail   = 0;
    bit timed_out = 1'b0;

    always #5 clk = ~clk;

    synth_div_pair u_dut (
        .ref_clk   (clk),
        .fb_clk    (clk),
        .rst_n     (rst_n),
        .pd_n      (pd_n),
        .ref_word  (ref_word),
        .fb_word   (fb_word),
        .ref_pulse (ref_pulse),
        .ref_toggle(ref_toggle),
        .ref_bad   (ref_bad),
        .fb_pulse  (fb_pulse),
        .fb_toggle (fb_toggle),
        .fb_bad    (fb_bad)
    );

    initial begin
        repeat (150000) @(posedge clk);
        timed_out = 1'b1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit pulse_of(input bit fb);
        return fb ? fb_pulse : ref_pulse;
    endfunction

    function automatic bit tog_of(input bit fb);
        return fb ? fb_toggle : ref_toggle;
    endfunction

    task automatic wait_pulse(input bit fb);
        do @(negedge clk); while (!pulse_of(fb) && !timed_out);
    endtask

    // counts negedges up to and including the next pulse; checks toggle behaviour (R4)
    task automatic measure(input bit fb, output int n, output bit tog_ok);
        bit prev;
        prev   = tog_of(fb);
        n      = 0;
        tog_ok = 1'b1;
        do begin
            @(negedge clk);
            n++;
            if (!pulse_of(fb) && tog_of(fb) != prev) tog_ok = 1'b0;
        end while (!pulse_of(fb) && !timed_out);
        if (tog_of(fb) == prev) tog_ok = 1'b0;
    endtask

    task automatic run_ref(input int w);
        int n, expn;
        bit tok;
        @(negedge clk);
        ref_word = 7'(w);
        @(negedge clk);
        chk(ref_bad == (w == 0), "R5 ref flag", int'(ref_bad), int'(w == 0));
        wait_pulse(1'b0);
        measure(1'b0, n, tok);
        expn = ((w == 0) ? 1 : w) + 2;
        chk(n == expn, (w == 0) ? "R5 ref clamp" : ((w == 127) ? "R6 ref max" : "R1 ref period"), n, expn);
        chk(tok, "R4 ref toggle", int'(tok), 1);
    endtask

    task automatic run_fb(input int w);
        int n, expn;
        bit tok;
        @(negedge clk);
        fb_word = 9'(w);
        @(negedge clk);
        chk(fb_bad == (w < 4), "R5 fb flag", int'(fb_bad), int'(w < 4));
        wait_pulse(1'b1);
        measure(1'b1, n, tok);
        expn = ((w < 4) ? 4 : w) + 8;
        chk(n == expn, (w < 4) ? "R5 fb clamp" : ((w == 511) ? "R6 fb max" : "R2 fb period"), n, expn);
        chk(tok, "R4 fb toggle", int'(tok), 1);
    endtask

    initial begin
        int n, ref_first, fb_first;
        bit tok, quiet;
        rst_n    = 1'b0;
        pd_n     = 1'b1;
        ref_word = 7'h7f;
        fb_word  = 9'h1ff;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(!ref_pulse && !fb_pulse, "R10 pulses in reset", int'(ref_pulse | fb_pulse), 0);
        chk(!ref_toggle && !fb_toggle, "R10 toggles in reset", int'(ref_toggle | fb_toggle), 0);
        chk(!ref_bad && !fb_bad, "R10 flags in reset", int'(ref_bad | fb_bad), 0);

        // R3 / R6: first pulse after reset with all-ones words
        rst_n     = 1'b1;
        ref_first = 0;
        fb_first  = 0;
        quiet     = 1'b1;
        for (int i = 1; i <= 600; i++) begin
            @(negedge clk);
            if (ref_pulse && ref_first == 0) ref_first = i;
            if (fb_pulse && fb_first == 0) fb_first = i;
            if (ref_first == 0 && ref_toggle) quiet = 1'b0;
        end
        chk(ref_first == 130, "R3 R6 ref first pulse", ref_first, 130);
        chk(fb_first == 520, "R3 R6 fb first pulse", fb_first, 520);
        chk(quiet, "R4 ref toggle low before first pulse", int'(quiet), 1);

        // R1 / R5 / R6: every reference word
        fb_word = 9'd20;
        for (int w = 0; w < 128; w++) run_ref(w);

        // R2 / R5 / R6: feedback illegal, low and top codes
        ref_word = 7'd10;
        for (int w = 0; w <= 20; w++) run_fb(w);
        run_fb(100);
        run_fb(255);
        run_fb(256);
        run_fb(400);
        run_fb(510);
        run_fb(511);

        // R3: pulse width one cycle
        @(negedge clk);
        ref_word = 7'd1;
        wait_pulse(1'b0);
        wait_pulse(1'b0);
        @(negedge clk);
        chk(!ref_pulse, "R3 pulse one cycle", int'(ref_pulse), 0);

        // R7: word change in the middle of a period
        ref_word = 7'd20;
        wait_pulse(1'b0);
        wait_pulse(1'b0);
        n = 0;
        repeat (5) begin
            @(negedge clk);
            n++;
        end
        ref_word = 7'd50;
        do begin
            @(negedge clk);
            n++;
        end while (!ref_pulse && !timed_out);
        chk(n == 22, "R7 old ratio completes", n, 22);
        measure(1'b0, n, tok);
        chk(n == 52, "R7 new ratio next period", n, 52);

        // R8: power-down
        @(negedge clk);
        pd_n = 1'b0;
        @(negedge clk);
        chk(!ref_pulse && !ref_toggle && !fb_pulse && !fb_toggle, "R8 outputs low after one edge",
            int'(ref_pulse | ref_toggle | fb_pulse | fb_toggle), 0);
        ref_word = 7'd3;
        fb_word  = 9'd10;
        quiet    = 1'b1;
        repeat (600) begin
            @(negedge clk);
            if (ref_pulse || ref_toggle || fb_pulse || fb_toggle) quiet = 1'b0;
        end
        chk(quiet, "R8 no activity during power-down", int'(quiet), 1);

        // R9: release power-down, first periods full length
        pd_n      = 1'b1;
        ref_first = 0;
        fb_first  = 0;
        for (int i = 1; i <= 40; i++) begin
            @(negedge clk);
            if (ref_pulse && ref_first == 0) begin
                ref_first = i;
                chk(ref_toggle, "R9 R4 ref toggle high at first pulse", int'(ref_toggle), 1);
            end
            if (fb_pulse && fb_first == 0) fb_first = i;
        end
        chk(ref_first == 6, "R9 ref first pulse after power-down", ref_first, 6);
        chk(fb_first == 19, "R9 fb first pulse after power-down", fb_first, 19);

        if (timed_out) chk(1'b0, "watchdog", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule